// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between free-running clock sources and the output pads of a clock generator. It handles three output families, each in its own clock domain. CPU-type outputs stop on a CPU stop pin. PCI-type outputs stop on a PCI stop pin, and so do any fixed-PCI and SRC-type outputs that are configured as stoppable. The SRC outputs can also be stopped by two active-low clock-request pins. A power-down input parks every output. For each output the block produces the gated clock and a pad-enable flag that says whether the pad is driven or tri-stated.

Every asynchronous control pin passes through a two-flop synchronizer in each destination domain. The enable decision is captured by a latch that is transparent only while the source clock is low. A gated output therefore starts and stops only on whole source pulses, and a stopped output that is still driven sits at logic low. The per-output configuration bits (enable, tri-state-when-stopped, stoppable, request-enable) come from an external register file as plain vectors.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, the synchronizers hold the stopped state. Until the release has been seen by two rising edges, every output is gated exactly as if all stop, request and power-down inputs were asserted.
- R2: A change of cpu_stp_ni first sampled at rising edge A takes effect from the high phase that starts at edge A+2. While stopped, each CPU output gives no pulses. Once released, each CPU output follows its source clock.
- R3: The plain PCI outputs always stop while pci_stp_ni is low, with the same two-edge latency.
- R4: A fixed-PCI or SRC output whose stoppable bit is 0 keeps running whatever pci_stp_ni does. An output whose stoppable bit is 1 stops with pci_stp_ni.
- R5: An SRC output whose request-enable bit is 1 stops while its request pin is high. With the default maps, req_b_ni governs SRC bits 1 to 4 and req_a_ni governs SRC bit 5; bit 0 has no request pin. An output whose request-enable bit is 0 ignores the pin.
- R6: While pd_i is high, every output of every family is stopped, regardless of its stoppable and request-enable bits. The same two-edge latency applies.
- R7: While an output is stopped, its pad-enable flag is the inverse of its tri-state bit: tri-state bit 1 clears the flag, tri-state bit 0 keeps the pad driven low.
- R8: An output whose enable bit is 0 gives no pulses and has its pad-enable flag at 0, whatever the stop inputs are doing.
- R9: A gated output is never high while its source clock is low. When it runs, it reproduces every full high phase of the source clock.
- R10: A change to a configuration bit made before the low phase that precedes rising edge N takes effect in the high phase that starts at edge N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU-family source clock |
| pci_clk_i | input | 1 | PCI-family source clock |
| src_clk_i | input | 1 | SRC-family source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stp_ni | input | 1 | CPU stop, active low, asynchronous |
| pci_stp_ni | input | 1 | PCI stop, active low, asynchronous |
| req_a_ni | input | 1 | Clock request A, active low, asynchronous |
| req_b_ni | input | 1 | Clock request B, active low, asynchronous |
| pd_i | input | 1 | Power-down, active high, asynchronous |
| cpu_oe_cfg_i | input | NC | CPU output enable bits |
| cpu_tri_cfg_i | input | NC | CPU tri-state-when-stopped bits |
| pci_oe_cfg_i | input | NP | PCI output enable bits |
| pci_tri_cfg_i | input | NP | PCI tri-state-when-stopped bits |
| pcif_oe_cfg_i | input | NF | Fixed-PCI output enable bits |
| pcif_tri_cfg_i | input | NF | Fixed-PCI tri-state-when-stopped bits |
| pcif_stp_en_i | input | NF | Fixed-PCI stoppable-by-PCI-stop bits |
| src_oe_cfg_i | input | NS | SRC output enable bits |
| src_tri_cfg_i | input | NS | SRC tri-state-when-stopped bits |
| src_stp_en_i | input | NS | SRC stoppable-by-PCI-stop bits |
| src_req_en_i | input | NS | SRC stoppable-by-request bits |
| cpu_clk_o | output | NC | Gated CPU clocks |
| cpu_oe_o | output | NC | CPU pad-enable flags |
| pci_clk_o | output | NP | Gated PCI clocks |
| pci_oe_o | output | NP | PCI pad-enable flags |
| pcif_clk_o | output | NF | Gated fixed-PCI clocks |
| pcif_oe_o | output | NF | Fixed-PCI pad-enable flags |
| src_clk_o | output | NS | Gated SRC clocks |
| src_oe_o | output | NS | SRC pad-enable flags |

## Verification
The assertions assume that the asynchronous pins and the configuration vectors never change near a rising edge of the destination clock. Under that assumption the value sampled two edges back equals the value that reached the synchronizer output. They also assume that configuration bits change before a low phase, so that the latched pad flag sampled at a rising edge agrees with the configuration sampled at that same edge. The stimulus drives all three source clocks from one bench clock. It changes every input only in the middle of the high phase, never at an edge. This holds for both the directed phases and the pseudo-random phase.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef struct packed {
    logic pd;
    logic stp;
    logic req_a;
    logic req_b;
  } stop_lvl_t;

  localparam int unsigned STOP_W = $bits(stop_lvl_t);
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int unsigned    W       = 4,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/csc_gate_cell.sv
module csc_gate_cell (
  input  logic clk_i,
  input  logic run_i,
  input  logic drive_i,
  output logic clk_o,
  output logic oe_o
);
  logic run_l;
  logic drive_l;

  // transparent only in the low phase: enable never changes mid-pulse
  always_latch begin
    if (!clk_i) begin
      run_l   <= run_i;
      drive_l <= drive_i;
    end
  end

  assign clk_o = clk_i & run_l;
  assign oe_o  = drive_l;
endmodule

// File: rtl/csc_domain.sv
module csc_domain
  import csc_pkg::*;
#(
  parameter int unsigned   N          = 4,
  parameter int unsigned   STAGES     = 2,
  parameter logic [N-1:0]  REQ_A_MAP  = '0,
  parameter logic [N-1:0]  REQ_B_MAP  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pd_i,
  input  logic         stp_i,
  input  logic         req_a_off_i,
  input  logic         req_b_off_i,
  input  logic [N-1:0] oe_cfg_i,
  input  logic [N-1:0] tri_cfg_i,
  input  logic [N-1:0] stp_en_i,
  input  logic [N-1:0] req_en_i,
  output logic [N-1:0] clk_o,
  output logic [N-1:0] oe_o
);
  stop_lvl_t raw_lvl;
  stop_lvl_t syn_lvl;

  assign raw_lvl = '{pd: pd_i, stp: stp_i, req_a: req_a_off_i, req_b: req_b_off_i};

  csc_sync #(
    .W      (STOP_W),
    .STAGES (STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lvl),
    .q_o   (syn_lvl)
  );

  for (genvar i = 0; i < N; i++) begin : g_out
    logic halt;
    logic run;
    logic drive;

    assign halt  = syn_lvl.pd
                 | (syn_lvl.stp   & stp_en_i[i])
                 | (syn_lvl.req_a & req_en_i[i] & REQ_A_MAP[i])
                 | (syn_lvl.req_b & req_en_i[i] & REQ_B_MAP[i]);
    assign run   = oe_cfg_i[i] & ~halt;
    assign drive = oe_cfg_i[i] & ~(halt & tri_cfg_i[i]);

    csc_gate_cell u_cell (
      .clk_i  (clk_i),
      .run_i  (run),
      .drive_i(drive),
      .clk_o  (clk_o[i]),
      .oe_o   (oe_o[i])
    );
  end
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int unsigned    NC            = 3,
  parameter int unsigned    NP            = 4,
  parameter int unsigned    NF            = 2,
  parameter int unsigned    NS            = 6,
  parameter int unsigned    SYNC_STAGES   = 2,
  parameter logic [NS-1:0]  SRC_REQ_A_MAP = 6'b100000,
  parameter logic [NS-1:0]  SRC_REQ_B_MAP = 6'b011110
) (
  input  logic          cpu_clk_i,
  input  logic          pci_clk_i,
  input  logic          src_clk_i,
  input  logic          rst_ni,
  input  logic          cpu_stp_ni,
  input  logic          pci_stp_ni,
  input  logic          req_a_ni,
  input  logic          req_b_ni,
  input  logic          pd_i,
  input  logic [NC-1:0] cpu_oe_cfg_i,
  input  logic [NC-1:0] cpu_tri_cfg_i,
  input  logic [NP-1:0] pci_oe_cfg_i,
  input  logic [NP-1:0] pci_tri_cfg_i,
  input  logic [NF-1:0] pcif_oe_cfg_i,
  input  logic [NF-1:0] pcif_tri_cfg_i,
  input  logic [NF-1:0] pcif_stp_en_i,
  input  logic [NS-1:0] src_oe_cfg_i,
  input  logic [NS-1:0] src_tri_cfg_i,
  input  logic [NS-1:0] src_stp_en_i,
  input  logic [NS-1:0] src_req_en_i,
  output logic [NC-1:0] cpu_clk_o,
  output logic [NC-1:0] cpu_oe_o,
  output logic [NP-1:0] pci_clk_o,
  output logic [NP-1:0] pci_oe_o,
  output logic [NF-1:0] pcif_clk_o,
  output logic [NF-1:0] pcif_oe_o,
  output logic [NS-1:0] src_clk_o,
  output logic [NS-1:0] src_oe_o
);
  localparam int unsigned NPT = NP + NF;

  logic [NPT-1:0] pci_all_clk;
  logic [NPT-1:0] pci_all_oe;

  csc_domain #(
    .N     (NC),
    .STAGES(SYNC_STAGES)
  ) u_cpu (
    .clk_i      (cpu_clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (pd_i),
    .stp_i      (~cpu_stp_ni),
    .req_a_off_i(1'b0),
    .req_b_off_i(1'b0),
    .oe_cfg_i   (cpu_oe_cfg_i),
    .tri_cfg_i  (cpu_tri_cfg_i),
    .stp_en_i   ({NC{1'b1}}),
    .req_en_i   ({NC{1'b0}}),
    .clk_o      (cpu_clk_o),
    .oe_o       (cpu_oe_o)
  );

  // plain PCI outputs always stoppable; fixed-PCI per configuration bit
  csc_domain #(
    .N     (NPT),
    .STAGES(SYNC_STAGES)
  ) u_pci (
    .clk_i      (pci_clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (pd_i),
    .stp_i      (~pci_stp_ni),
    .req_a_off_i(1'b0),
    .req_b_off_i(1'b0),
    .oe_cfg_i   ({pcif_oe_cfg_i, pci_oe_cfg_i}),
    .tri_cfg_i  ({pcif_tri_cfg_i, pci_tri_cfg_i}),
    .stp_en_i   ({pcif_stp_en_i, {NP{1'b1}}}),
    .req_en_i   ({NPT{1'b0}}),
    .clk_o      (pci_all_clk),
    .oe_o       (pci_all_oe)
  );

  assign pci_clk_o  = pci_all_clk[NP-1:0];
  assign pci_oe_o   = pci_all_oe[NP-1:0];
  assign pcif_clk_o = pci_all_clk[NPT-1:NP];
  assign pcif_oe_o  = pci_all_oe[NPT-1:NP];

  csc_domain #(
    .N        (NS),
    .STAGES   (SYNC_STAGES),
    .REQ_A_MAP(SRC_REQ_A_MAP),
    .REQ_B_MAP(SRC_REQ_B_MAP)
  ) u_src (
    .clk_i      (src_clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (pd_i),
    .stp_i      (~pci_stp_ni),
    .req_a_off_i(req_a_ni),
    .req_b_off_i(req_b_ni),
    .oe_cfg_i   (src_oe_cfg_i),
    .tri_cfg_i  (src_tri_cfg_i),
    .stp_en_i   (src_stp_en_i),
    .req_en_i   (src_req_en_i),
    .clk_o      (src_clk_o),
    .oe_o       (src_oe_o)
  );
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int unsigned    NC            = 3,
  parameter int unsigned    NP            = 4,
  parameter int unsigned    NF            = 2,
  parameter int unsigned    NS            = 6,
  parameter int unsigned    SYNC_STAGES   = 2,
  parameter logic [NS-1:0]  SRC_REQ_A_MAP = 6'b100000,
  parameter logic [NS-1:0]  SRC_REQ_B_MAP = 6'b011110
) (
  input logic          cpu_clk_i,
  input logic          pci_clk_i,
  input logic          src_clk_i,
  input logic          rst_ni,
  input logic          cpu_stp_ni,
  input logic          pci_stp_ni,
  input logic          req_a_ni,
  input logic          req_b_ni,
  input logic          pd_i,
  input logic [NC-1:0] cpu_oe_cfg_i,
  input logic [NC-1:0] cpu_tri_cfg_i,
  input logic [NP-1:0] pci_oe_cfg_i,
  input logic [NP-1:0] pci_tri_cfg_i,
  input logic [NF-1:0] pcif_oe_cfg_i,
  input logic [NF-1:0] pcif_tri_cfg_i,
  input logic [NF-1:0] pcif_stp_en_i,
  input logic [NS-1:0] src_oe_cfg_i,
  input logic [NS-1:0] src_tri_cfg_i,
  input logic [NS-1:0] src_stp_en_i,
  input logic [NS-1:0] src_req_en_i,
  input logic [NC-1:0] cpu_clk_o,
  input logic [NC-1:0] cpu_oe_o,
  input logic [NP-1:0] pci_clk_o,
  input logic [NP-1:0] pci_oe_o,
  input logic [NF-1:0] pcif_clk_o,
  input logic [NF-1:0] pcif_oe_o,
  input logic [NS-1:0] src_clk_o,
  input logic [NS-1:0] src_oe_o
);
  // edges since reset, so $past never reaches into the reset period
  logic [1:0] cpu_age_q, pci_age_q, src_age_q;
  logic       cpu_rdy, pci_rdy, src_rdy;
  logic [NS-1:0] src_free;

  always_ff @(posedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) cpu_age_q <= '0;
    else if (cpu_age_q != 2'd3) cpu_age_q <= cpu_age_q + 2'd1;
  always_ff @(posedge pci_clk_i or negedge rst_ni)
    if (!rst_ni) pci_age_q <= '0;
    else if (pci_age_q != 2'd3) pci_age_q <= pci_age_q + 2'd1;
  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni) src_age_q <= '0;
    else if (src_age_q != 2'd3) src_age_q <= src_age_q + 2'd1;

  assign cpu_rdy  = cpu_age_q >= 2'd2;
  assign pci_rdy  = pci_age_q >= 2'd2;
  assign src_rdy  = src_age_q >= 2'd2;
  assign src_free = ~src_stp_en_i & ~(src_req_en_i & (SRC_REQ_A_MAP | SRC_REQ_B_MAP));

  assert_cpu_park_R2: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_rdy && !$past(cpu_stp_ni, 2) |-> cpu_oe_o == (cpu_oe_cfg_i & ~cpu_tri_cfg_i));
  assert_cpu_run_R2: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_rdy && $past(cpu_stp_ni, 2) && !$past(pd_i, 2) |-> cpu_oe_o == cpu_oe_cfg_i);
  assert_pci_park_R3: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    pci_rdy && !$past(pci_stp_ni, 2) |-> pci_oe_o == (pci_oe_cfg_i & ~pci_tri_cfg_i));
  assert_src_free_R4: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_rdy && !$past(pd_i, 2) |-> ((src_oe_o ^ src_oe_cfg_i) & src_free) == '0);
  assert_req_b_park_R5: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_rdy && $past(req_b_ni, 2) |->
      ((src_oe_o ^ (src_oe_cfg_i & ~src_tri_cfg_i)) & src_req_en_i & SRC_REQ_B_MAP) == '0);
  assert_pd_src_R6: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_rdy && $past(pd_i, 2) |-> src_oe_o == (src_oe_cfg_i & ~src_tri_cfg_i));
  assert_pd_pcif_R6: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    pci_rdy && $past(pd_i, 2) |-> pcif_oe_o == (pcif_oe_cfg_i & ~pcif_tri_cfg_i));
  assert_oe_off_R8: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (~cpu_oe_cfg_i & cpu_oe_o) == '0);
  assert_cpu_low_R9: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_clk_o == '0);
  assert_pci_low_R9: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    pci_clk_o == '0 && pcif_clk_o == '0);
  assert_src_low_R9: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_clk_o == '0);
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .NC           (NC),
  .NP           (NP),
  .NF           (NF),
  .NS           (NS),
  .SYNC_STAGES  (SYNC_STAGES),
  .SRC_REQ_A_MAP(SRC_REQ_A_MAP),
  .SRC_REQ_B_MAP(SRC_REQ_B_MAP)
) u_chk (.*);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
  localparam int NC = 3, NP = 4, NF = 2, NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stp_n, pci_stp_n, rqa_n, rqb_n, pd;
  logic [NC-1:0] cpu_oe, cpu_tri;
  logic [NP-1:0] pci_oe, pci_tri;
  logic [NF-1:0] pcif_oe, pcif_tri, pcif_en;
  logic [NS-1:0] src_oe, src_tri, src_en, src_rq;
  logic [NC-1:0] cpu_clk_o, cpu_oe_o;
  logic [NP-1:0] pci_clk_o, pci_oe_o;
  logic [NF-1:0] pcif_clk_o, pcif_oe_o;
  logic [NS-1:0] src_clk_o, src_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  // stop-level history {pd, cpu, pci, a, b}; index 2 is what the outputs currently reflect
  logic [4:0] hist [3];

  always #4 clk = ~clk;

  clk_stop_ctrl u_dut (
    .cpu_clk_i(clk), .pci_clk_i(clk), .src_clk_i(clk), .rst_ni(rst_n),
    .cpu_stp_ni(cpu_stp_n), .pci_stp_ni(pci_stp_n), .req_a_ni(rqa_n), .req_b_ni(rqb_n),
    .pd_i(pd),
    .cpu_oe_cfg_i(cpu_oe), .cpu_tri_cfg_i(cpu_tri),
    .pci_oe_cfg_i(pci_oe), .pci_tri_cfg_i(pci_tri),
    .pcif_oe_cfg_i(pcif_oe), .pcif_tri_cfg_i(pcif_tri), .pcif_stp_en_i(pcif_en),
    .src_oe_cfg_i(src_oe), .src_tri_cfg_i(src_tri), .src_stp_en_i(src_en),
    .src_req_en_i(src_rq),
    .cpu_clk_o(cpu_clk_o), .cpu_oe_o(cpu_oe_o), .pci_clk_o(pci_clk_o), .pci_oe_o(pci_oe_o),
    .pcif_clk_o(pcif_clk_o), .pcif_oe_o(pcif_oe_o), .src_clk_o(src_clk_o), .src_oe_o(src_oe_o)
  );

  task automatic cmp(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_high(input string tag);
    logic h_pd, h_cs, h_ps, h_ra, h_rb, halt;
    logic [NC-1:0] e_cc, e_co;
    logic [NP-1:0] e_pc, e_po;
    logic [NF-1:0] e_fc, e_fo;
    logic [NS-1:0] e_sc, e_so;
    {h_pd, h_cs, h_ps, h_ra, h_rb} = hist[2];
    for (int i = 0; i < NC; i++) begin
      halt = h_pd | h_cs;
      e_cc[i] = cpu_oe[i] & ~halt;
      e_co[i] = cpu_oe[i] & ~(halt & cpu_tri[i]);
    end
    for (int i = 0; i < NP; i++) begin
      halt = h_pd | h_ps;
      e_pc[i] = pci_oe[i] & ~halt;
      e_po[i] = pci_oe[i] & ~(halt & pci_tri[i]);
    end
    for (int i = 0; i < NF; i++) begin
      halt = h_pd | (h_ps & pcif_en[i]);
      e_fc[i] = pcif_oe[i] & ~halt;
      e_fo[i] = pcif_oe[i] & ~(halt & pcif_tri[i]);
    end
    for (int i = 0; i < NS; i++) begin
      halt = h_pd | (h_ps & src_en[i]);
      if (i == 5) halt = halt | (h_ra & src_rq[i]);
      if (i >= 1 && i <= 4) halt = halt | (h_rb & src_rq[i]);
      e_sc[i] = src_oe[i] & ~halt;
      e_so[i] = src_oe[i] & ~(halt & src_tri[i]);
    end
    cmp(tag, "cpu_clk", 16'(cpu_clk_o), 16'(e_cc));
    cmp(tag, "cpu_oe", 16'(cpu_oe_o), 16'(e_co));
    cmp(tag, "pci_clk", 16'(pci_clk_o), 16'(e_pc));
    cmp(tag, "pci_oe", 16'(pci_oe_o), 16'(e_po));
    cmp(tag, "pcif_clk", 16'(pcif_clk_o), 16'(e_fc));
    cmp(tag, "pcif_oe", 16'(pcif_oe_o), 16'(e_fo));
    cmp(tag, "src_clk", 16'(src_clk_o), 16'(e_sc));
    cmp(tag, "src_oe", 16'(src_oe_o), 16'(e_so));
  endtask

  // one source cycle; inputs are set by the caller in the high phase before the call
  task automatic step(input string tag);
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = {pd, ~cpu_stp_n, ~pci_stp_n, rqa_n, rqb_n};
    @(negedge clk);
    #2;
    cmp("R9", "low_phase", 16'({cpu_clk_o, pci_clk_o, pcif_clk_o, src_clk_o}), 16'd0);
    @(posedge clk);
    #2;
    check_high(tag);
  endtask

  task automatic run_all();
    pd = 1'b0; cpu_stp_n = 1'b1; pci_stp_n = 1'b1; rqa_n = 1'b0; rqb_n = 1'b0;
  endtask

  initial begin
    pd = 1'b1; cpu_stp_n = 1'b0; pci_stp_n = 1'b0; rqa_n = 1'b1; rqb_n = 1'b1;
    cpu_oe = '1; cpu_tri = 3'b101; pci_oe = '1; pci_tri = 4'b0110;
    pcif_oe = '1; pcif_tri = 2'b01; pcif_en = '0;
    src_oe = '1; src_tri = 6'b100101; src_en = '0; src_rq = '0;
    for (int k = 0; k < 3; k++) hist[k] = 5'b11111;
    @(posedge clk); #2;
    for (int k = 0; k < 4; k++) step("R1");
    rst_n = 1'b1;
    run_all();
    for (int k = 0; k < 2; k++) step("R1");
    for (int k = 0; k < 4; k++) step("R2");
    // CPU stop and release
    cpu_stp_n = 1'b0;
    for (int k = 0; k < 4; k++) step("R2");
    cpu_stp_n = 1'b1;
    for (int k = 0; k < 4; k++) step("R2");
    // PCI stop: plain PCI always, PCIF/SRC per stoppable bit
    pcif_en = 2'b01; src_en = 6'b101010;
    step("R4");
    pci_stp_n = 1'b0;
    for (int k = 0; k < 4; k++) step("R3");
    pcif_en = 2'b10; src_en = 6'b010101;
    for (int k = 0; k < 3; k++) step("R4");
    pci_stp_n = 1'b1;
    for (int k = 0; k < 4; k++) step("R4");
    // clock-request pins
    src_en = '0; src_rq = 6'b110110;
    rqb_n = 1'b1;
    for (int k = 0; k < 4; k++) step("R5");
    rqa_n = 1'b1;
    for (int k = 0; k < 4; k++) step("R5");
    rqb_n = 1'b0;
    src_rq = 6'b001001;
    for (int k = 0; k < 4; k++) step("R5");
    rqa_n = 1'b0;
    for (int k = 0; k < 3; k++) step("R5");
    // power-down overrides masks; tri-state bits set stopped pad state
    src_rq = '0; src_en = '0; pcif_en = '0;
    pd = 1'b1;
    for (int k = 0; k < 4; k++) step("R6");
    cpu_tri = 3'b010; pci_tri = 4'b1001; pcif_tri = 2'b10; src_tri = 6'b011010;
    for (int k = 0; k < 3; k++) step("R7");
    pd = 1'b0; cpu_stp_n = 1'b0;
    cpu_tri = 3'b111;
    for (int k = 0; k < 4; k++) step("R7");
    cpu_tri = 3'b000;
    for (int k = 0; k < 3; k++) step("R7");
    cpu_stp_n = 1'b1;
    // output enables off, with and without stops
    cpu_oe = 3'b010; pci_oe = 4'b0101; pcif_oe = 2'b10; src_oe = 6'b100110;
    for (int k = 0; k < 4; k++) step("R8");
    pci_stp_n = 1'b0; pd = 1'b1;
    for (int k = 0; k < 4; k++) step("R8");
    run_all();
    for (int k = 0; k < 3; k++) step("R8");
    // configuration changes land on the next rising edge
    for (int k = 0; k < 8; k++) begin
      src_oe = ~src_oe; cpu_oe = ~cpu_oe; pcif_tri = ~pcif_tri;
      step("R10");
    end
    // stop toggling every cycle stresses restart latency
    for (int k = 0; k < 10; k++) begin
      cpu_stp_n = ~cpu_stp_n;
      step("R2");
    end
    cpu_stp_n = 1'b1;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      cpu_stp_n = r[0]; pci_stp_n = r[1]; rqa_n = r[2]; rqb_n = r[3]; pd = (r[7:4] == 4'd0);
      if (r[10:8] == 3'd0) begin
        logic [31:0] c;
        c = $urandom;
        cpu_oe = c[2:0]; cpu_tri = c[5:3]; pci_oe = c[9:6]; pci_tri = c[13:10];
        pcif_oe = c[15:14]; pcif_tri = c[17:16]; pcif_en = c[19:18];
        src_oe = c[25:20]; src_tri = c[31:26];
        c = $urandom;
        src_en = c[5:0]; src_rq = c[11:6];
      end
      step("R9");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_200_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule